// File: doc/BRIEF.md
# Host Register Port on a Shared Pixel Bus

This block gives a host processor access to a small bank of 8-bit control registers. It does this over the low byte of the 16-bit pixel data bus that the image datapath also uses. A host-select input decides who owns the bus. While it is high, the block decodes a 2-bit register address and two active-low strobes, one for read and one for write. While it is low, the strobes are ignored and the bus belongs to the pixel datapath.

Register 0 is the mode register. Its bit 0 is the GO bit, which starts image processing. The block does not drive the pads itself. It produces the outgoing bus value and separate output enables for the low and high bytes, and the pad ring applies them.

After reset the pixel bus stays undriven until GO is set. While GO is set, an active-low busy output tells the host that an image is in flight. The datapath ends processing with a one-cycle completion pulse.

Top module: `hrp_host_port`

## Requirements
- R1: While `host_sel` is low, the read and write strobes have no effect: no register changes and the host read enable stays low.
- R2: Address 1 and address 2 select two plain 8-bit registers. Register n appears on `cfg_flat[8n+7:8n]`, and register 0 (the mode register) appears on `cfg_flat[7:0]`.
- R3: A write takes the data on `bus_in_lo` and the address when the rising edge of `host_wr_n` is detected, after two synchronizer stages. The new value is visible on the third rising clock edge after the strobe rises. Data and address must be held that long.
- R4: A host read raises `bus_oe_lo` on the second clock edge after `host_rd_n` falls while `host_sel` is high. During the read, `bus_out[7:0]` carries the register at `host_addr` as sampled on the previous edge. The enable drops as soon as `host_sel` falls, or two edges after the strobe rises.
- R5: During a host read, `bus_oe_hi` equals `bus_oe_lo` and `bus_out[15:8]` is zero.
- R6: Address 3 is unused. A read of it returns 0 and a write to it is discarded.
- R7: After the synchronous active-low reset, GO is 0, all registers are 0, `busy_n` is 1 and both enables are 0.
- R8: While `host_sel` is low, both enables are high only when GO is 1 and `pix_drive_req` is 1, and `bus_out` then equals `pix_wdata`. Otherwise the bus is undriven and `bus_out` is 0.
- R9: `busy_n` is the inverse of GO. A write of bit 0 to address 0 is ignored while GO is already 1. A `proc_done` pulse clears GO on the next edge and takes priority over a write in the same cycle.
- R10: Bits 7:1 of the mode register are stored on every write to address 0, whether or not GO is 1, and are read back with GO in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | High gives the bus to the host |
| host_addr | input | 2 | Register address |
| host_wr_n | input | 1 | Active-low write strobe, asynchronous |
| host_rd_n | input | 1 | Active-low read strobe, asynchronous |
| bus_in_lo | input | 8 | Low byte of the pixel bus as seen at the pads |
| pix_wdata | input | 16 | Data the pixel datapath wants to drive |
| pix_drive_req | input | 1 | The pixel datapath requests to drive the bus |
| proc_done | input | 1 | One-cycle pulse: image processing finished |
| bus_out | output | 16 | Value for the bus output drivers |
| bus_oe_lo | output | 1 | Output enable, low byte |
| bus_oe_hi | output | 1 | Output enable, high byte |
| busy_n | output | 1 | Active low while an image is processed |
| go | output | 1 | GO bit of the mode register |
| cfg_flat | output | 24 | Register contents, register n at bits 8n+7:8n |

## Verification
The bench tries distinct byte patterns at each address (0xA5, 0x3C, all ones) so that a swapped or aliased address decode shows up as a wrong read-back. Strobe pulses made while `host_sel` is low separate correct gating from a port that listens all the time. GO writes are tried from idle, while busy, and after a completion pulse, which separates the idle-only set rule from the always-stored upper mode bits. Pixel-side requests made before and after GO show whether the bus stays quiet after reset.

// File: rtl/hrp_pkg.sv
// Package hrp_pkg
// Shared constants for the host register port.
// Assumes 8-bit registers and a 2-bit register address.
package hrp_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int MODE_IX = 0;   // index of the mode register holding GO
    localparam int GO_BIT  = 0;   // position of GO inside the mode register
endpackage

// File: rtl/hrp_sync.sv
// Module hrp_sync
// Brings an asynchronous level into the clock domain through a flop chain.
// Assumes the input is a slow strobe level, and RST_VAL is its idle level.
module hrp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hrp_regfile.sv
// Module hrp_regfile
// Holds the mode register (with GO) and the plain configuration registers,
// and provides a combinational read mux. Addresses at or above USED_REGS
// read as zero and are not written.
// Assumes wr_fire is a single-cycle pulse in the clock domain.
module hrp_regfile
    import hrp_pkg::*;
#(
    parameter int USED_REGS = 3,
    localparam int CFG_W    = USED_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              proc_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_byte,
    output logic              go,
    output logic [CFG_W-1:0]  cfg_flat
);
    logic [REG_W-1:0] reg_q [USED_REGS];
    logic             go_q;
    logic [REG_W-1:1] mode_hi_q;

    genvar g;
    generate
        for (g = 0; g < USED_REGS; g++) begin : g_reg
            if (g == MODE_IX) begin : g_mode
                // Upper mode bits follow every write; GO sets only from idle.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        go_q      <= 1'b0;
                        mode_hi_q <= '0;
                    end else begin
                        if (wr_fire && wr_addr == ADDR_W'(g)) begin
                            mode_hi_q <= wr_data[REG_W-1:1];
                        end
                        if (proc_done) begin
                            go_q <= 1'b0;
                        end else if (wr_fire && wr_addr == ADDR_W'(g) && !go_q) begin
                            go_q <= wr_data[GO_BIT];
                        end
                    end
                end
                assign reg_q[g] = {mode_hi_q, go_q};
            end else begin : g_plain
                logic [REG_W-1:0] val_q;
                // Plain register loads on a write to its address.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        val_q <= '0;
                    end else if (wr_fire && wr_addr == ADDR_W'(g)) begin
                        val_q <= wr_data;
                    end
                end
                assign reg_q[g] = val_q;
            end
            assign cfg_flat[g*REG_W +: REG_W] = reg_q[g];
        end
    endgenerate

    // Read mux; unused addresses fall through to zero.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < USED_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_byte = reg_q[i];
            end
        end
    end

    assign go = go_q;

    // R9
    go_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> $past(wr_fire && wr_addr == ADDR_W'(MODE_IX)
                               && wr_data[GO_BIT] && !proc_done));

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_done |=> !go_q);
endmodule

// File: rtl/hrp_bus_ctl.sv
// Module hrp_bus_ctl
// Chooses the bus owner and forms the outgoing bus value and byte enables.
// The host owns the bus while host_sel is high, and the pixel datapath may
// drive only while GO is set. Assumes rd_active is already synchronized.
module hrp_bus_ctl
    import hrp_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int USED_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              rd_active,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  rd_byte,
    input  logic              go,
    input  logic              pix_drive_req,
    input  logic [BUS_W-1:0]  pix_wdata,
    output logic [BUS_W-1:0]  bus_out,
    output logic              oe_lo,
    output logic              oe_hi
);
    logic [REG_W-1:0] rd_data_q;
    logic             host_oe;
    logic             pix_oe;

    // Register the addressed byte so the bus sees a clean value.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_byte;
    end

    assign host_oe = rd_active && host_sel;
    assign pix_oe  = !host_sel && go && pix_drive_req;

    // Pick the outgoing bus value by owner.
    always_comb begin
        if (host_oe)     bus_out = {{(BUS_W-REG_W){1'b0}}, rd_data_q};
        else if (pix_oe) bus_out = pix_wdata;
        else             bus_out = '0;
    end

    assign oe_lo = host_oe || pix_oe;
    assign oe_hi = host_oe || pix_oe;

    // R6
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_oe && $past(int'(rd_addr) >= USED_REGS)) |-> bus_out[REG_W-1:0] == '0);

    // R5
    hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && oe_lo) |-> (oe_hi && bus_out[BUS_W-1:REG_W] == '0));
endmodule

// File: rtl/hrp_host_port.sv
// Module hrp_host_port
// Top of the host register port. It synchronizes the host strobes, detects
// the rising edge of the write strobe, and ties the register file to the
// bus control. Assumes the host holds address and data for three clocks
// after the write strobe rises.
module hrp_host_port
    import hrp_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int USED_REGS   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = USED_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [REG_W-1:0]  bus_in_lo,
    input  logic [BUS_W-1:0]  pix_wdata,
    input  logic              pix_drive_req,
    input  logic              proc_done,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe_lo,
    output logic              bus_oe_hi,
    output logic              busy_n,
    output logic              go,
    output logic [CFG_W-1:0]  cfg_flat
);
    logic wr_level, wr_sync, wr_prev, wr_fire;
    logic rd_level, rd_sync;
    logic [REG_W-1:0] rd_byte;

    // The strobes count only while the host owns the bus.
    assign wr_level = !host_sel || host_wr_n;
    assign rd_level = host_sel && !host_rd_n;

    hrp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .d(wr_level), .q(wr_sync));

    hrp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .d(rd_level), .q(rd_sync));

    // Keep the last synchronized write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_sync;
    end

    assign wr_fire = wr_sync && !wr_prev;

    hrp_regfile #(.USED_REGS(USED_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(host_addr),
        .wr_data(bus_in_lo), .proc_done(proc_done), .rd_addr(host_addr),
        .rd_byte(rd_byte), .go(go), .cfg_flat(cfg_flat));

    hrp_bus_ctl #(.BUS_W(BUS_W), .USED_REGS(USED_REGS)) u_bus (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .rd_active(rd_sync),
        .rd_addr(host_addr), .rd_byte(rd_byte), .go(go),
        .pix_drive_req(pix_drive_req), .pix_wdata(pix_wdata),
        .bus_out(bus_out), .oe_lo(bus_oe_lo), .oe_hi(bus_oe_hi));

    assign busy_n = !go;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sel && !go) |-> (!bus_oe_lo && !bus_oe_hi));

    // R1
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> !(bus_oe_lo && bus_out != pix_wdata));
endmodule

// File: tb/hrp_host_port_bench.sv
module hrp_host_port_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_sel = 0;
    logic [1:0]  host_addr = 0;
    logic        host_wr_n = 1;
    logic        host_rd_n = 1;
    logic [7:0]  bus_in_lo = 0;
    logic [15:0] pix_wdata = 16'hBEEF;
    logic        pix_drive_req = 0;
    logic        proc_done = 0;
    logic [15:0] bus_out;
    logic        bus_oe_lo, bus_oe_hi, busy_n, go;
    logic [23:0] cfg_flat;

    int checks = 0;
    int errors = 0;

    hrp_host_port u_hrp_host_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
        .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .bus_in_lo(bus_in_lo),
        .pix_wdata(pix_wdata), .pix_drive_req(pix_drive_req),
        .proc_done(proc_done), .bus_out(bus_out), .bus_oe_lo(bus_oe_lo),
        .bus_oe_hi(bus_oe_hi), .busy_n(busy_n), .go(go), .cfg_flat(cfg_flat));

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: strobe histories as integer queues.
    int wq[$];
    int rq[$];
    logic [7:0] m_reg [4];
    logic       m_go;
    logic [7:0] m_rd;

    always @(posedge clk) begin
        logic fire;
        logic [7:0] mode_now;
        logic hoe, poe;
        logic [15:0] exp_bus;
        if (!rst_n) begin
            wq = '{1, 1, 1};
            rq = '{0, 0};
            foreach (m_reg[i]) m_reg[i] = 0;
            m_go = 0;
            m_rd = 0;
        end else begin
            fire = (wq[1] == 1) && (wq[2] == 0);
            mode_now = {m_reg[0][7:1], m_go};
            m_rd = (host_addr == 0) ? mode_now :
                   (host_addr == 3) ? 8'h00 : m_reg[host_addr];
            if (fire && host_addr != 3) begin
                if (host_addr == 0) m_reg[0][7:1] = bus_in_lo[7:1];
                else m_reg[host_addr] = bus_in_lo;
            end
            if (proc_done) m_go = 0;
            else if (fire && host_addr == 0 && !m_go) m_go = bus_in_lo[0];
            void'(wq.pop_back());
            wq.push_front((!host_sel || host_wr_n) ? 1 : 0);
            void'(rq.pop_back());
            rq.push_front((host_sel && !host_rd_n) ? 1 : 0);
        end
        #2;
        if (rst_n) begin
            hoe = (rq[1] == 1) && host_sel;
            poe = !host_sel && m_go && pix_drive_req;
            exp_bus = hoe ? {8'h00, m_rd} : (poe ? pix_wdata : 16'h0);
            check(host_sel ? "R4" : "R8", {31'b0, bus_oe_lo}, {31'b0, hoe || poe});
            check("R5", {31'b0, bus_oe_hi}, {31'b0, hoe || poe});
            check(host_sel ? "R4" : "R8", {16'b0, bus_out}, {16'b0, exp_bus});
            check("R9", {30'b0, go, busy_n}, {30'b0, m_go, !m_go});
            check("R2", {8'b0, cfg_flat}, {8'b0, m_reg[2], m_reg[1], m_reg[0][7:1], m_go});
        end
    end

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1; host_addr = a; bus_in_lo = d; host_wr_n = 0;
        repeat (3) @(negedge clk);
        host_wr_n = 1;
        repeat (5) @(negedge clk);
        host_sel = 0;
    endtask

    task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_sel = 1; host_addr = a; host_rd_n = 0;
        repeat (3) @(posedge clk);
        #2;
        check(req, {31'b0, bus_oe_lo}, 32'd1);
        check(req, {24'b0, bus_out[7:0]}, {24'b0, exp});
        check("R5", {16'b0, bus_out[15:8], 7'b0, bus_oe_hi}, 32'd1);
        @(negedge clk);
        host_rd_n = 1;
        repeat (3) @(negedge clk);
        host_sel = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        check("R7", {30'b0, go, busy_n}, 32'd1);
        check("R7", {8'b0, cfg_flat}, 32'd0);
        check("R7", {30'b0, bus_oe_lo, bus_oe_hi}, 32'd0);
        // R8: a pixel request before GO leaves the bus undriven
        pix_drive_req = 1;
        repeat (3) @(negedge clk);
        check("R8", {31'b0, bus_oe_lo}, 32'd0);
        pix_drive_req = 0;
        // R2, R3 plain registers
        host_write(2'd1, 8'hA5);
        check("R3", {24'b0, cfg_flat[15:8]}, 32'hA5);
        host_write(2'd2, 8'h3C);
        check("R2", {24'b0, cfg_flat[23:16]}, 32'h3C);
        host_read(2'd1, 8'hA5, "R4");
        host_read(2'd2, 8'h3C, "R4");
        // R6 unused address
        host_write(2'd3, 8'hFF);
        check("R6", {8'b0, cfg_flat}, {8'b0, 24'h3CA500});
        host_read(2'd3, 8'h00, "R6");
        // R1 strobes while deselected
        @(negedge clk);
        host_sel = 0; host_addr = 2'd1; bus_in_lo = 8'h00; host_wr_n = 0; host_rd_n = 0;
        repeat (3) @(negedge clk);
        check("R1", {31'b0, bus_oe_lo}, 32'd0);
        host_wr_n = 1; host_rd_n = 1;
        repeat (5) @(negedge clk);
        check("R1", {24'b0, cfg_flat[15:8]}, 32'hA5);
        // R9, R10 GO from idle with upper bits
        host_write(2'd0, 8'h81);
        check("R9", {30'b0, go, busy_n}, 32'd2);
        check("R10", {24'b0, cfg_flat[7:0]}, 32'h81);
        // R8 pixel drive while GO
        pix_drive_req = 1;
        repeat (2) @(negedge clk);
        check("R8", {15'b0, bus_oe_lo, bus_out}, {15'b0, 1'b1, 16'hBEEF});
        pix_drive_req = 0;
        // R9: clearing GO by write is ignored while busy, R10 upper bits stored
        host_write(2'd0, 8'h40);
        check("R9", {31'b0, go}, 32'd1);
        check("R10", {24'b0, cfg_flat[7:0]}, 32'h41);
        host_read(2'd0, 8'h41, "R10");
        // R9 completion clears GO
        @(negedge clk);
        proc_done = 1;
        @(negedge clk);
        proc_done = 0;
        check("R9", {30'b0, go, busy_n}, 32'd1);
        pix_drive_req = 1;
        repeat (2) @(negedge clk);
        check("R8", {31'b0, bus_oe_lo}, 32'd0);
        pix_drive_req = 0;
        host_write(2'd0, 8'h01);
        check("R9", {31'b0, go}, 32'd1);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule